// File: doc/BRIEF.md
# X-Tolerant Scan Response Compactor

This block takes one bit from each of several parallel scan chains in every scan-out cycle. It folds that word into a narrower response word for the tester. Each response bit is the XOR of a fixed subset of chain bits. The subsets come from a binary matrix with one row per chain, and a chain feeds response bit j exactly when bit j of its row is set.

The matrix is built at elaboration. Every row has three ones, and the first rows in ascending numeric order are used. Because the rows are non-zero, pairwise distinct and of odd weight, any of the following always changes the compacted word: a flipped value on one chain, a flipped value on two chains, or a flipped value on any odd number of chains within the same cycle. With 8 chains there are 156 such error combinations.

The compactor sits between the scan-chain outputs and the tester pins. Both sides use a valid/ready handshake. A word moves when valid and ready are both high on a rising clock edge. With the output register enabled, the stage holds a single word. In that mode `in_ready` is high when the stage is empty, or when the downstream side takes the held word in the same cycle. A stalled word stays valid and unchanged until it is taken. With the register disabled, the stage is a pure wire path: valid goes forward and ready goes backward unchanged.

Top module: `xcmp_compactor`

## Requirements
- R1: Response bit j equals the XOR of every chain bit i whose row has bit j set. The default rows for chains 0..7 are 00111, 01011, 01101, 01110, 10011, 10101, 10110 and 11001, written with response bit 4 on the left.
- R2: Driving a one-hot chain word returns that chain's row. The eight returned rows are all non-zero, all distinct, and each has an odd number of ones.
- R3: Flipping any single chain relative to a fault-free word changes the response (8 of 8 cases).
- R4: Flipping any two chains in the same cycle changes the response (28 of 28 cases).
- R5: Flipping 3, 5 or 7 chains in the same cycle changes the response (120 of 120 cases), so 156 combinations are detected in total.
- R6: In registered mode, a word accepted on an edge shows `out_valid` high, carrying its compacted value, from that edge onward.
- R7: In registered mode, while `out_valid` is high and `out_ready` is low, `out_valid` stays high, `out_comp` holds its value and `in_ready` is low. Once `out_ready` returns high, `in_ready` is high again.
- R8: `rst` is synchronous and active high. One edge with `rst` high leaves `out_valid` low, even when a word was held.
- R9: With the output register disabled, `out_valid` equals `in_valid`, `in_ready` equals `out_ready`, and `out_comp` is the compacted value of the current `in_chain`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Chain word present |
| in_ready | output | 1 | Compactor accepts the chain word |
| in_chain | input | NUM_CHAINS | One scan-out bit per chain |
| out_valid | output | 1 | Compacted word present |
| out_ready | input | 1 | Tester side takes the compacted word |
| out_comp | output | OUT_W | Compacted response word |

## Verification
The bound checker runs every cycle. It checks that an accepted word reappears as its compacted value one edge later, that a stalled word is held with the input side blocked, and that reset clears the valid flag. In pass-through mode it also checks the wire-level handshake and the data.

The detection guarantee depends on the matrix as a whole and not on any single cycle, so only the bench's scenarios can show it. The bench sends every 1-, 2-, 3-, 5- and 7-chain error against a fault-free word and counts how many response pairs differ. It also reads back each row through one-hot stimulus to confirm that the rows are distinct and of odd weight.

// File: rtl/xcmp_pkg.sv
package xcmp_pkg;

  localparam int unsigned MAX_CHAINS = 16;
  localparam int unsigned MAX_OUTS   = 16;

  typedef logic [MAX_OUTS-1:0]   row_t;
  typedef row_t [MAX_CHAINS-1:0] row_tab_t;

  // Take the first `chains` values of width `outs` that have exactly `wt`
  // ones, in ascending order. With an odd wt the rows are non-zero,
  // pairwise distinct and of odd weight by construction.
  function automatic row_tab_t gen_rows(input int unsigned chains,
                                        input int unsigned outs,
                                        input int unsigned wt);
    row_tab_t    tab;
    int unsigned k;
    tab = '0;
    k   = 0;
    for (int unsigned v = 1; v < (32'd1 << outs); v++) begin
      int unsigned pc;
      pc = 0;
      for (int unsigned b = 0; b < outs; b++) pc += (v >> b) & 32'd1;
      if (pc == wt && k < chains) begin
        tab[k] = row_t'(v);
        k++;
      end
    end
    return tab;
  endfunction

endpackage

// File: rtl/xcmp_xor_tree.sv
module xcmp_xor_tree #(
  parameter int unsigned       NUM_CHAINS = 8,
  parameter int unsigned       OUT_W      = 5,
  parameter xcmp_pkg::row_tab_t ROW_TABLE = xcmp_pkg::gen_rows(8, 5, 3)
) (
  input  logic [NUM_CHAINS-1:0] chain_i,
  output logic [OUT_W-1:0]      comp_o
);

  // One reduction tree per response bit. The taps are elaboration constants,
  // so each tree keeps only the chains that feed that column.
  for (genvar j = 0; j < OUT_W; j++) begin : g_col
    logic [NUM_CHAINS-1:0] tap;
    for (genvar i = 0; i < NUM_CHAINS; i++) begin : g_tap
      if (ROW_TABLE[i][j]) begin : g_on
        assign tap[i] = chain_i[i];
      end else begin : g_off
        assign tap[i] = 1'b0;
      end
    end
    assign comp_o[j] = ^tap;
  end

endmodule

// File: rtl/xcmp_out_stage.sv
module xcmp_out_stage #(
  parameter int unsigned W       = 5,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  if (REG_OUT) begin : g_reg
    logic         full_q;
    logic [W-1:0] data_q;

    // Accept when empty, or when the held word leaves on this same edge.
    assign in_ready = !full_q || out_ready;

    always_ff @(posedge clk) begin
      if (rst) begin
        full_q <= 1'b0;
      end else if (in_ready) begin
        full_q <= in_valid;
      end
    end

    always_ff @(posedge clk) begin
      if (in_valid && in_ready) data_q <= in_data;
    end

    assign out_valid = full_q;
    assign out_data  = data_q;
  end else begin : g_wire
    logic unused_clk_rst;
    assign unused_clk_rst = clk ^ rst;
    assign out_valid      = in_valid;
    assign in_ready       = out_ready;
    assign out_data       = in_data;
  end

endmodule

// File: rtl/xcmp_compactor.sv
module xcmp_compactor #(
  parameter int unsigned        NUM_CHAINS = 8,
  parameter int unsigned        OUT_W      = 5,
  parameter int unsigned        ROW_WEIGHT = 3,
  parameter bit                 REG_OUT    = 1'b1,
  parameter xcmp_pkg::row_tab_t ROW_TABLE  =
    xcmp_pkg::gen_rows(NUM_CHAINS, OUT_W, ROW_WEIGHT)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [NUM_CHAINS-1:0] in_chain,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [OUT_W-1:0]      out_comp
);

  logic [OUT_W-1:0] comp_w;

  xcmp_xor_tree #(
    .NUM_CHAINS(NUM_CHAINS),
    .OUT_W     (OUT_W),
    .ROW_TABLE (ROW_TABLE)
  ) u_tree (
    .chain_i(in_chain),
    .comp_o (comp_w)
  );

  xcmp_out_stage #(
    .W      (OUT_W),
    .REG_OUT(REG_OUT)
  ) u_stage (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (comp_w),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_comp)
  );

endmodule

// File: rtl/xcmp_checker.sv
module xcmp_checker #(
  parameter int unsigned        NUM_CHAINS = 8,
  parameter int unsigned        OUT_W      = 5,
  parameter bit                 REG_OUT    = 1'b1,
  parameter xcmp_pkg::row_tab_t ROW_TABLE  = xcmp_pkg::gen_rows(8, 5, 3)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic [NUM_CHAINS-1:0] in_chain,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [OUT_W-1:0]      out_comp
);

  function automatic logic [OUT_W-1:0] fold(input logic [NUM_CHAINS-1:0] d);
    logic [OUT_W-1:0] r;
    r = '0;
    for (int i = 0; i < int'(NUM_CHAINS); i++) begin
      if (d[i]) r = r ^ ROW_TABLE[i][OUT_W-1:0];
    end
    return r;
  endfunction

  if (REG_OUT) begin : g_reg_chk
    AST_CAPTURE_DATA: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> (out_valid && out_comp == fold($past(in_chain)))); // R6
    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_comp))); // R7
    AST_BLOCK_INPUT: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |-> !in_ready); // R7
    AST_RESET_IDLE: assert property (@(posedge clk)
      rst |=> !out_valid); // R8
  end else begin : g_wire_chk
    AST_WIRE_HANDSHAKE: assert property (@(posedge clk) disable iff (rst)
      (out_valid == in_valid) && (in_ready == out_ready)); // R9
    AST_WIRE_DATA: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> out_comp == fold(in_chain)); // R1
  end

endmodule

bind xcmp_compactor xcmp_checker #(
  .NUM_CHAINS(NUM_CHAINS),
  .OUT_W     (OUT_W),
  .REG_OUT   (REG_OUT),
  .ROW_TABLE (ROW_TABLE)
) u_xcmp_checker (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_chain (in_chain),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_comp (out_comp)
);

// File: tb/xcmp_compactor_bench.sv
module xcmp_compactor_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_chain = '0;
  logic       out_ready = 1'b1;
  logic       in_ready, out_valid;
  logic [4:0] out_comp;
  logic       w_in_ready, w_out_valid;
  logic [4:0] w_out_comp;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int rdy_mode = 0;
  logic [7:0] lf = 8'h5b;

  logic [4:0] exp_q[$];
  logic [4:0] obs_q[$];
  int         cat_q[$];
  logic [4:0] rows [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  xcmp_compactor u_xcmp_compactor (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_chain(in_chain), .out_valid(out_valid), .out_ready(out_ready),
    .out_comp(out_comp)
  );

  xcmp_compactor #(.REG_OUT(1'b0)) u_xcmp_wire (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(w_in_ready),
    .in_chain(in_chain), .out_valid(w_out_valid), .out_ready(out_ready),
    .out_comp(w_out_comp)
  );

  function automatic logic [4:0] model(input logic [7:0] d);
    logic [4:0] r;
    r = '0;
    for (int i = 0; i < 8; i++) if (d[i]) r = r ^ rows[i];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Driver: offer a word, push its expected compaction once it is accepted.
  task automatic send(input logic [7:0] d);
    @(posedge clk); #1;
    in_valid = 1'b1;
    in_chain = d;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    exp_q.push_back(model(d));
  endtask

  task automatic idle();
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Ready pattern on the tester side.
  always begin
    @(posedge clk); #1;
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    case (rdy_mode)
      0:       out_ready = 1'b1;
      1:       out_ready = lf[0] | lf[2];
      default: out_ready = 1'b0;
    endcase
  end

  // Monitor: scoreboard compare for the registered unit, live check for the wire unit.
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1", "unexpected output word", int'(out_comp), -1);
      end else begin
        logic [4:0] e;
        e = exp_q.pop_front();
        chk(out_comp == e, "R1", "compacted word", int'(out_comp), int'(e));
      end
      obs_q.push_back(out_comp);
    end
    if (!rst && in_valid) begin
      chk(w_out_valid && w_out_comp == model(in_chain), "R9", "wire data",
          int'(w_out_comp), int'(model(in_chain)));
      chk(w_in_ready == out_ready, "R9", "wire ready", int'(w_in_ready), int'(out_ready));
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rows = '{5'b00111, 5'b01011, 5'b01101, 5'b01110,
             5'b10011, 5'b10101, 5'b10110, 5'b11001};
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(!out_valid, "R8", "valid during reset", int'(out_valid), 0);
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    chk(!out_valid, "R8", "valid after reset", int'(out_valid), 0);

    // R2: one-hot words return rows; check non-zero, odd weight, distinct.
    obs_q.delete();
    for (int i = 0; i < 8; i++) send(8'(1 << i));
    idle();
    drain();
    chk(obs_q.size() == 8, "R2", "row count", obs_q.size(), 8);
    if (obs_q.size() == 8) begin
      for (int i = 0; i < 8; i++) begin
        chk(obs_q[i] != 0, "R2", "row non-zero", int'(obs_q[i]), 1);
        chk($countones(obs_q[i]) % 2 == 1, "R2", "row odd weight",
            $countones(obs_q[i]), 3);
        for (int k = i + 1; k < 8; k++)
          chk(obs_q[i] != obs_q[k], "R2", "rows distinct", int'(obs_q[k]), -1);
      end
    end

    // R1: assorted patterns under irregular back-pressure.
    rdy_mode = 1;
    send(8'h00); send(8'hff); send(8'ha5); send(8'h5a);
    send(8'h3c); send(8'h81); send(8'h7e); send(8'h12);
    idle();
    drain();

    // R3 / R4 / R5: every 1, 2, 3, 5, 7 chain error against a fault-free word.
    obs_q.delete();
    cat_q.delete();
    for (int e = 1; e < 256; e++) begin
      int pc;
      logic [7:0] g;
      pc = $countones(e[7:0]);
      if (pc == 1 || pc == 2 || pc == 3 || pc == 5 || pc == 7) begin
        g = 8'(e * 37 + 11);
        send(g);
        send(g ^ e[7:0]);
        cat_q.push_back(pc);
      end
    end
    idle();
    drain();
    rdy_mode = 0;
    begin
      int n1, n2, nodd, nall;
      n1 = 0; n2 = 0; nodd = 0; nall = 0;
      chk(obs_q.size() == 2 * cat_q.size(), "R5", "pair count",
          obs_q.size(), 2 * cat_q.size());
      if (obs_q.size() == 2 * cat_q.size()) begin
        for (int p = 0; p < cat_q.size(); p++) begin
          if (obs_q[2*p] != obs_q[2*p+1]) begin
            nall++;
            if (cat_q[p] == 1) n1++;
            else if (cat_q[p] == 2) n2++;
            else nodd++;
          end
        end
      end
      chk(n1 == 8, "R3", "single errors seen", n1, 8);
      chk(n2 == 28, "R4", "double errors seen", n2, 28);
      chk(nodd == 120, "R5", "odd errors seen", nodd, 120);
      chk(nall == 156, "R5", "total errors seen", nall, 156);
    end

    // R6 / R7: stall the tester side with a word held.
    rdy_mode = 2;
    repeat (2) @(posedge clk);
    #1;
    in_valid = 1'b1;
    in_chain = 8'h3c;
    @(negedge clk);
    chk(in_ready, "R7", "ready when empty", int'(in_ready), 1);
    exp_q.push_back(model(8'h3c));
    @(posedge clk); #1;
    in_chain = 8'hc3;
    @(negedge clk);
    chk(out_valid && out_comp == model(8'h3c), "R6", "word after one edge",
        int'(out_comp), int'(model(8'h3c)));
    chk(!in_ready, "R7", "input blocked", int'(in_ready), 0);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(out_valid && out_comp == model(8'h3c), "R7", "held word",
          int'(out_comp), int'(model(8'h3c)));
      chk(!in_ready, "R7", "still blocked", int'(in_ready), 0);
    end
    rdy_mode = 0;
    @(negedge clk);
    chk(in_ready, "R7", "ready after release", int'(in_ready), 1);
    exp_q.push_back(model(8'hc3));
    idle();
    drain();

    // R8: reset drops a held word.
    rdy_mode = 2;
    repeat (2) @(posedge clk);
    #1;
    in_valid = 1'b1;
    in_chain = 8'h81;
    @(posedge clk); #1;
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid, "R8", "word held before reset", int'(out_valid), 1);
    @(posedge clk); #1;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(!out_valid, "R8", "reset clears held word", int'(out_valid), 0);
    @(posedge clk); #1;
    rst = 1'b0;
    rdy_mode = 0;
    @(negedge clk);
    chk(!out_valid, "R8", "idle after reset", int'(out_valid), 0);
    chk(exp_q.size() == 0, "R1", "scoreboard empty", exp_q.size(), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule